// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block lives in an always-on domain next to the main interrupt controller. Every shared peripheral interrupt line passes through it to the downstream controller unchanged. For each of two CPUs it also holds a set of wakeup-enable words, one bit per interrupt line. When an enabled line is active, the block raises that CPU's wakeup request so the core can leave a low-power state.

The enable words for both CPUs and a one-bit wake-mode register are reached through a simple memory-mapped port. Writes are single-cycle and reads are combinational. With the mode bit clear, both cores wake together. With it set, each core wakes only on its own enables. Interrupt levels pass through a two-flop synchronizer before the wakeup logic uses them. The wakeup request is registered once after that.

Top module: `wakegen_top`

## Requirements
- R1: `irq_out` equals `irq_in` combinationally at all times. Neither the enable bits nor the mode bit change it.
- R2: After reset, every enable bit of both CPUs reads zero, the mode bit reads zero and `wake_req` is zero.
- R3: The enable word for CPU c and bank i is at byte address c*0x400 + 4*i. A write to a mapped word is visible on a read of the same address from the next cycle. Other words are untouched.
- R4: Interrupt line n is governed by bit (n mod 32) of bank (n >> 5). A line is qualifying for a CPU when the line is high and that CPU's bit for it is set.
- R5: `wake_req` rises on the third rising clock edge after a qualifying line goes high (two synchronizer stages plus one output register). It stays high while the line stays high, and falls on the third edge after the line drops.
- R6: With the mode bit set (bit 0 of the word at 0x800), each CPU's wakeup request depends only on its own enable words.
- R7: With the mode bit clear, a qualifying line for either CPU raises the wakeup request of both CPUs.
- R8: Writing 0x00000000 to an enable word masks all 32 of its lines. Writing 0xFFFFFFFF makes all 32 qualifying when high.
- R9: A read returns zero and a write has no effect for any of these addresses: an address not aligned to 4, a bank index at or above the bank count, a page above the mode page, or any mode-page word other than 0x800. Bits 31:1 of the mode word read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the always-on domain |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_BANKS*32 | Incoming level interrupt lines |
| irq_out | output | NUM_BANKS*32 | Unmodified lines to the downstream controller |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| wake_req | output | NUM_CPUS | Per-CPU wakeup request |

## Verification
The bench targets the three-edge latency window, so that a design missing a synchronizer stage or adding an extra one shows the request a cycle early or late. It probes the edges of the map: the last bank, bank index 5 on CPU 1, misaligned addresses and mode-page aliases. A faulty decoder would alias those onto real enable words or return stale data. Line 159 and line 37 check the bank and bit split, where an off-by-one would wake the wrong CPU. Switching between joint and independent modes with the enables held fixed exposes an inverted or ignored mode bit. A random phase covers the remaining combinations of enable words and sparse line patterns.

// File: rtl/wakegen_pkg.sv
package wakegen_pkg;
  localparam int WORD_W     = 32;
  localparam int PAGE_LSB   = 10;   // 0x400 bytes per CPU page
  localparam int IDX_LSB    = 2;    // 4 bytes per word

  function automatic int line_bank(input int n);
    return n >> 5;
  endfunction

  function automatic int line_bit(input int n);
    return n & 31;
  endfunction

  function automatic int mode_offset(input int ncpu);
    return ncpu << PAGE_LSB;
  endfunction
endpackage

// File: rtl/wakegen_sync.sv
module wakegen_sync #(
  parameter int WIDTH = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/wakegen_regs.sv
module wakegen_regs
  import wakegen_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 12,
  localparam int NUM_LINES = NUM_BANKS * WORD_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [WORD_W-1:0]                  wdata,
  output logic [WORD_W-1:0]                  rdata,
  output logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_bits,
  output logic                               mode_indep
);
  localparam int MODE_ADDR = mode_offset(NUM_CPUS);

  int   sel_page;
  int   sel_idx;
  logic aligned;
  logic en_hit;
  logic mode_hit;

  always_comb begin
    sel_page = int'(addr[ADDR_W-1:PAGE_LSB]);
    sel_idx  = int'(addr[PAGE_LSB-1:IDX_LSB]);
    aligned  = (addr[IDX_LSB-1:0] == '0);
    en_hit   = aligned && (sel_page < NUM_CPUS) && (sel_idx < NUM_BANKS);
    mode_hit = (addr == ADDR_W'(MODE_ADDR));
  end

  logic [WORD_W-1:0] bank_q [NUM_CPUS][NUM_BANKS];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank_q[c][b] <= '0;
        else if (wr_en && en_hit && sel_page == c && sel_idx == b)
          bank_q[c][b] <= wdata;
      end
      assign en_bits[c][b*WORD_W +: WORD_W] = bank_q[c][b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_indep <= 1'b0;
    else if (wr_en && mode_hit)
      mode_indep <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    if (mode_hit)
      rdata = {{(WORD_W-1){1'b0}}, mode_indep};
    for (int c = 0; c < NUM_CPUS; c++)
      for (int b = 0; b < NUM_BANKS; b++)
        if (en_hit && sel_page == c && sel_idx == b)
          rdata = bank_q[c][b];
  end
endmodule

// File: rtl/wakegen_combine.sv
module wakegen_combine #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_LINES = 160
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_LINES-1:0]               irq_sync,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_bits,
  input  logic                               mode_indep,
  output logic [NUM_CPUS-1:0]                evt_raw,
  output logic [NUM_CPUS-1:0]                wake_q
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_evt
    assign evt_raw[c] = |(irq_sync & en_bits[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wake_q[c] <= 1'b0;
      else
        wake_q[c] <= mode_indep ? evt_raw[c] : (|evt_raw);
    end
  end
endmodule

// File: rtl/wakegen_top.sv
module wakegen_top
  import wakegen_pkg::*;
#(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 12,
  localparam int NUM_LINES = NUM_BANKS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic [NUM_CPUS-1:0]  wake_req
);
  logic [NUM_LINES-1:0]               irq_sync;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_bits;
  logic                               mode_indep;
  logic [NUM_CPUS-1:0]                evt_raw;

  assign irq_out = irq_in;

  wakegen_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (irq_in),
    .q     (irq_sync)
  );

  wakegen_regs #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .en_bits    (en_bits),
    .mode_indep (mode_indep)
  );

  wakegen_combine #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_LINES (NUM_LINES)
  ) u_combine (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_sync   (irq_sync),
    .en_bits    (en_bits),
    .mode_indep (mode_indep),
    .evt_raw    (evt_raw),
    .wake_q     (wake_req)
  );
endmodule

// File: rtl/wakegen_checker.sv
module wakegen_checker #(
  parameter int NUM_CPUS  = 2,
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 160
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_LINES-1:0]               irq_in,
  input logic [NUM_LINES-1:0]               irq_out,
  input logic                               reg_wr,
  input logic [ADDR_W-1:0]                  reg_addr,
  input logic [31:0]                        reg_rdata,
  input logic [NUM_CPUS-1:0]                wake_req,
  input logic [NUM_CPUS-1:0]                evt_raw,
  input logic [NUM_CPUS-1:0][NUM_LINES-1:0] en_bits,
  input logic                               mode_indep
);
  logic addr_mapped;
  always_comb begin
    addr_mapped = 1'b0;
    if (reg_addr % 4 == 0) begin
      if ((reg_addr / 1024) < NUM_CPUS && ((reg_addr % 1024) / 4) < NUM_BANKS)
        addr_mapped = 1'b1;
      if (reg_addr == ADDR_W'(NUM_CPUS * 1024))
        addr_mapped = 1'b1;
    end
  end

  p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == irq_in);

  p_no_event_no_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_raw) == '0) |-> (wake_req == '0));

  p_indep_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_indep) |-> (wake_req == $past(evt_raw)));

  p_joint_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mode_indep)) |-> (wake_req == '0 || wake_req == '1));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_mapped) |-> (reg_rdata == '0));

  p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr)) |-> $stable(en_bits));
endmodule

bind wakegen_top wakegen_checker #(
  .NUM_CPUS  (NUM_CPUS),
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .NUM_LINES (NUM_LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .irq_out    (irq_out),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .wake_req   (wake_req),
  .evt_raw    (evt_raw),
  .en_bits    (en_bits),
  .mode_indep (mode_indep)
);

// File: tb/wakegen_top_tb.sv
`timescale 1ns/1ps
module wakegen_top_tb;
  localparam int NC = 2;
  localparam int NB = 5;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_out;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] wake_req;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_en [NC][NB];
  logic        m_mode;

  always #10 clk = ~clk;

  wakegen_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake_req(wake_req)
  );

  function automatic logic [31:0] model_rd(input logic [11:0] a);
    int pg = int'(a) / 1024;
    int ix = (int'(a) % 1024) / 4;
    if (a % 4 != 0) return 32'h0;
    if (pg < NC && ix < NB) return m_en[pg][ix];
    if (int'(a) == NC * 1024) return {31'h0, m_mode};
    return 32'h0;
  endfunction

  function automatic logic [NC-1:0] model_wake(input logic [NL-1:0] lines);
    logic [NC-1:0] raw = '0;
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < NL; n++)
        if (lines[n] && m_en[c][n / 32][n % 32]) raw[c] = 1'b1;
    if (m_mode) return raw;
    return (raw != 0) ? {NC{1'b1}} : '0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int pg = int'(a) / 1024;
    int ix = (int'(a) % 1024) / 4;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a % 4 == 0) begin
      if (pg < NC && ix < NB) m_en[pg][ix] = d;
      else if (int'(a) == NC * 1024) m_mode = d[0];
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, model_rd(a));
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) m_en[c][b] = '0;
    m_mode = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    check("R2 wake", wake_req, 0);
    rd_check("R2 cpu0 bank0", 12'h000);
    rd_check("R2 cpu1 bank4", 12'h410);
    rd_check("R2 mode", 12'h800);
    irq_in = '1; settle();
    check("R2 no wake with all lines high", wake_req, 0);
    check("R1 passthrough all ones", irq_out == irq_in, 1);
    irq_in = '0; settle();

    // R3: map and readback
    wr(12'h40C, 32'hA5A5_0001);
    rd_check("R3 cpu1 bank3", 12'h40C);
    check("R3 readback value", reg_rdata, 32'hA5A5_0001);
    rd_check("R3 cpu0 bank3 untouched", 12'h00C);

    // R9: ignored accesses
    wr(12'h414, 32'hFFFF_FFFF);
    rd_check("R9 bank5 reads zero", 12'h414);
    wr(12'h40E, 32'h1234_5678);
    rd_check("R9 misaligned ignored", 12'h40C);
    check("R9 misaligned keeps value", reg_rdata, 32'hA5A5_0001);
    wr(12'hC00, 32'hFFFF_FFFF);
    rd_check("R9 page3 reads zero", 12'hC00);
    wr(12'h804, 32'h1);
    rd_check("R9 mode alias ignored", 12'h800);
    check("R9 mode still zero", reg_rdata, 0);
    wr(12'h800, 32'hFFFF_FFFF);
    rd_check("R9 mode upper bits zero", 12'h800);
    check("R9 mode reads one", reg_rdata, 1);
    wr(12'h40C, 32'h0);

    // R5 / R4: latency, line 37 -> bank1 bit5 for cpu0, independent mode
    wr(12'h004, 32'h0000_0020);
    settle();
    @(negedge clk);
    irq_in[37] = 1'b1;
    @(negedge clk); check("R5 edge1 low", wake_req, 2'b00);
    @(negedge clk); check("R5 edge2 low", wake_req, 2'b00);
    @(negedge clk); check("R5 edge3 high", wake_req, 2'b01);
    repeat (5) @(negedge clk);
    check("R5 held while line high", wake_req, 2'b01);
    check("R6 cpu1 unaffected", wake_req[1], 1'b0);
    irq_in[37] = 1'b0;
    @(negedge clk); check("R5 fall edge1 still high", wake_req, 2'b01);
    @(negedge clk); check("R5 fall edge2 still high", wake_req, 2'b01);
    @(negedge clk); check("R5 fall edge3 low", wake_req, 2'b00);

    // R4 / R6: line 159 -> bank4 bit31 for cpu1
    wr(12'h410, 32'h8000_0000);
    irq_in[159] = 1'b1; settle();
    check("R4 line159 wakes cpu1 only", wake_req, 2'b10);
    irq_in[36] = 1'b1; settle();
    check("R4 neighbour line36 no cpu0 wake", wake_req, 2'b10);
    irq_in = '0;

    // R7: joint mode
    wr(12'h800, 32'h0);
    irq_in[159] = 1'b1; settle();
    check("R7 joint wakes both", wake_req, 2'b11);
    irq_in = '0; settle();
    check("R7 joint drops", wake_req, 2'b00);

    // R8: unmask all / mask all
    wr(12'h800, 32'h1);
    wr(12'h008, 32'hFFFF_FFFF);
    irq_in[70] = 1'b1; settle();
    check("R8 unmask all", wake_req, 2'b01);
    wr(12'h008, 32'h0); settle();
    check("R8 mask all", wake_req, 2'b00);
    irq_in = '0;

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom % 4;
      logic [11:0] a;
      logic [31:0] d;
      a = 12'(($urandom % 4) * 1024 + ($urandom % 8) * 4);
      if ($urandom % 8 == 0) a = a + 12'($urandom % 4);
      if ($urandom % 6 == 0) a = 12'h800;
      d = (sel == 0) ? 32'h0 : (sel == 1) ? 32'hFFFF_FFFF : ($urandom & $urandom);
      wr(a, d);
      @(negedge clk);
      for (int w = 0; w < NB; w++)
        irq_in[w*32 +: 32] = $urandom & $urandom & $urandom;
      settle();
      check("R4 R6 R7 random wake", wake_req, model_wake(irq_in));
      check("R1 random passthrough", irq_out == irq_in, 1);
      rd_check("R3 R9 random read", 12'($urandom % 4096));
      rd_check("R3 random readback", a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule